// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns an asynchronous serial line back into parallel characters. A clock enable that pulses at sixteen times the bit rate paces all of its work. While the line is idle, the receiver watches for a high-to-low change. It then confirms the start bit at the start bit's midpoint. After that it takes one sample from the middle of each following bit. It collects five to eight data bits, least significant first. When parity is enabled it also samples a parity bit, and it then samples one stop bit. A control strobe loads the character length and the parity mode at run time.

A finished character goes into a single holding register, and `data_avail` rises. This gives a one-entry output stream: `data_avail` acts as the valid flag, and a pulse on `clr_avail` is the consumer's acknowledge. The serial line cannot be paused, so there is no back-pressure toward the line. If a new character completes while the previous one has not been acknowledged, the new character replaces the old one and `overrun` is raised. The received byte reaches `rd_data` only while `data_oe` is high. The three error flags reach their pins only while `stat_oe` is high. Otherwise these outputs read 0.

The line input is expected to be synchronous to `clk` already. Generating the bit-rate enable is left to the surrounding logic.

Top module: `serial_rx`

## Requirements
- R1: While idle, a frame begins on a tick where the line reads 0 and the previous tick's sample was 1. The line is sampled again on the 8th tick after that tick. If it reads 1 there, the event is dropped: no flag or held byte changes, and the receiver goes back to idle.
- R2: After a start bit is confirmed, each further bit (data, then parity, then stop) is sampled once, on every 16th tick counted from the start-bit sample.
- R3: The character length code `cfg_len` selects 00=5, 01=6, 10=7 and 11=8 data bits. The first data bit received lands in bit 0, and unused upper bits are 0. `rd_data` shows the held byte while `data_oe` is 1 and shows 0 otherwise.
- R4: `cfg_strobe` loads `cfg_len`, `cfg_par_en` and `cfg_par_odd`. After reset the setting is 8 data bits with no parity. A frame uses the setting that was loaded when its start edge was detected.
- R5: `data_avail` rises in the cycle after the stop-bit sample. It stays high until a `clr_avail` pulse. When a completion and a clear fall on the same clock edge, the completion wins.
- R6: With parity enabled, the parity flag is set when the count of 1s across the data bits and the parity bit is odd in even mode (`cfg_par_odd`=0), or even in odd mode. With parity disabled the flag is 0 and no parity bit is sampled.
- R7: The framing flag is set when the stop-bit sample is 0. Only one stop bit is checked. The receiver is idle right after that sample, and the next frame needs a 1-then-0 seen on successive ticks.
- R8: The overrun flag is set when a character completes while `data_avail` is high and is not being cleared on that edge. The new byte replaces the held one.
- R9: The parity, framing and overrun flags are rewritten at each completed character and hold their value in between. They appear on their pins only while `stat_oe` is 1, and read 0 otherwise.
- R10: In cycles without `tick` the receiver does not advance, whatever the line does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Enable at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| cfg_strobe | input | 1 | Loads the configuration inputs |
| cfg_len | input | 2 | Data length code (00=5 .. 11=8) |
| cfg_par_en | input | 1 | 1 = parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| data_oe | input | 1 | Enables rd_data |
| rd_data | output | 8 | Held character, 0 when disabled |
| data_avail | output | 1 | Character held and not yet acknowledged |
| clr_avail | input | 1 | Acknowledge, clears data_avail |
| stat_oe | input | 1 | Enables the error flags |
| par_err | output | 1 | Parity mismatch on last character |
| frm_err | output | 1 | Stop bit sampled as 0 |
| overrun | output | 1 | Last character overwrote an unacknowledged one |

## Verification
If the tick counter or the sampling phase is wrong inside the block, the error shows up at the ports when the frame ends. A bit sampled off-center or a shifted bit index appears as a wrong `rd_data` value, or as false parity or framing flags, in the cycle after the stop sample. That is roughly ten bit times after the fault. A stuck state machine appears as `data_avail` never rising, or as a glitch being accepted as a character. A bench model sampling at the same tick positions, compared every cycle, catches this within one cycle of the expected completion.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP
  } rx_state_e;

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       par_odd;
  } rx_cfg_t;

  localparam rx_cfg_t CFG_RESET = '{len: 2'b11, par_en: 1'b0, par_odd: 1'b0};
endpackage

// File: rtl/srx_cfg_reg.sv
module srx_cfg_reg
  import srx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe,
  input  logic [1:0] len,
  input  logic       par_en,
  input  logic       par_odd,
  output rx_cfg_t    cfg_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= CFG_RESET;
    else if (strobe) cfg_q <= '{len: len, par_en: par_en, par_odd: par_odd};
  end
endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  rx_cfg_t           cfg,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              par_err,
  output logic              frm_err
);
  localparam int CNT_W   = $clog2(OVS);
  localparam int IDX_W   = $clog2(DATA_W);
  localparam int MIN_LEN = DATA_W - 3;
  localparam int HALF    = OVS / 2;

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] sr;
  logic              prev;
  logic              pbit;
  rx_cfg_t           lat;
  logic [IDX_W:0]    nbits;
  logic              at_center;

  assign nbits     = (IDX_W+1)'(MIN_LEN) + (IDX_W+1)'(lat.len);
  assign at_center = (cnt == CNT_W'(OVS-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      idx   <= '0;
      sr    <= '0;
      prev  <= 1'b1;
      pbit  <= 1'b0;
      lat   <= CFG_RESET;
    end else if (tick) begin
      prev <= rxd;
      case (state)
        S_IDLE: begin
          if (prev && !rxd) begin
            state <= S_START;
            cnt   <= '0;
            lat   <= cfg;
            sr    <= '0;
          end
        end
        S_START: begin
          if (cnt == CNT_W'(HALF-1)) begin
            cnt <= '0;
            idx <= '0;
            state <= rxd ? S_IDLE : S_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DATA: begin
          if (at_center) begin
            cnt <= '0;
            sr  <= {rxd, sr[DATA_W-1:1]};
            if ({1'b0, idx} == nbits - 1'b1)
              state <= lat.par_en ? S_PAR : S_STOP;
            else
              idx <= idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PAR: begin
          if (at_center) begin
            cnt   <= '0;
            pbit  <= rxd;
            state <= S_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STOP: begin
          if (at_center) begin
            cnt   <= '0;
            state <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign done    = tick && (state == S_STOP) && at_center;
  assign data    = sr >> (DATA_W - int'(nbits));
  assign frm_err = !rxd;
  assign par_err = lat.par_en && ((^data ^ pbit) != lat.par_odd);

  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(state)); // R10
  AST_GLITCH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && state == S_START && cnt == CNT_W'(HALF-1) && rxd) |=> state == S_IDLE); // R1
  AST_SHORT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && lat.len == 2'b00) |-> (data >> MIN_LEN) == '0); // R3
endmodule

// File: rtl/srx_hold.sv
module srx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] data_in,
  input  logic              perr_in,
  input  logic              ferr_in,
  input  logic              clr,
  output logic [DATA_W-1:0] data_q,
  output logic              avail_q,
  output logic              perr_q,
  output logic              ferr_q,
  output logic              ovr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= '0;
      avail_q <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else if (done) begin
      data_q  <= data_in;
      avail_q <= 1'b1;
      perr_q  <= perr_in;
      ferr_q  <= ferr_in;
      ovr_q   <= avail_q && !clr;
    end else if (clr) begin
      avail_q <= 1'b0;
    end
  end

  AST_AVAIL_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> avail_q); // R5
  AST_CLEAR_DROPS_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && clr) |=> !avail_q); // R5
  AST_OVERRUN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && avail_q && !clr) |=> ovr_q); // R8
endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import srx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              cfg_strobe,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              data_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic              data_avail,
  input  logic              clr_avail,
  input  logic              stat_oe,
  output logic              par_err,
  output logic              frm_err,
  output logic              overrun
);
  rx_cfg_t           cfg_q;
  logic              f_done, f_perr, f_ferr;
  logic [DATA_W-1:0] f_data, h_data;
  logic              h_perr, h_ferr, h_ovr;

  srx_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .strobe(cfg_strobe), .len(cfg_len),
    .par_en(cfg_par_en), .par_odd(cfg_par_odd), .cfg_q(cfg_q)
  );

  srx_frame #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .cfg(cfg_q),
    .done(f_done), .data(f_data), .par_err(f_perr), .frm_err(f_ferr)
  );

  srx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .done(f_done), .data_in(f_data),
    .perr_in(f_perr), .ferr_in(f_ferr), .clr(clr_avail),
    .data_q(h_data), .avail_q(data_avail), .perr_q(h_perr),
    .ferr_q(h_ferr), .ovr_q(h_ovr)
  );

  assign rd_data = data_oe ? h_data : '0;
  assign par_err = stat_oe & h_perr;
  assign frm_err = stat_oe & h_ferr;
  assign overrun = stat_oe & h_ovr;
endmodule

// File: tb/serial_rx_tb.sv
module serial_rx_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic rxd = 1'b1;
  logic cfg_strobe = 1'b0;
  logic [1:0] cfg_len = 2'b11;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic data_oe = 1'b1, stat_oe = 1'b1, clr_avail = 1'b0;
  logic [7:0] rd_data;
  logic data_avail, par_err, frm_err, overrun;

  int total = 0, bad = 0, cycles = 0;
  bit tick_en = 1'b1;
  int tdiv = 0;

  serial_rx u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
    .cfg_strobe(cfg_strobe), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .data_oe(data_oe), .rd_data(rd_data),
    .data_avail(data_avail), .clr_avail(clr_avail), .stat_oe(stat_oe),
    .par_err(par_err), .frm_err(frm_err), .overrun(overrun)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    tdiv <= (tdiv + 1) % 4;
    tick <= tick_en && (tdiv == 2);
  end

  // behavioural reference: tick index since the start edge, sample points at 8+16k
  int m_tk = -1, m_len = 8, f_len = 8;
  bit m_pe = 0, m_po = 0, f_pe = 0, f_po = 0, m_prev = 1, m_pb = 0;
  bit m_av = 0, m_perr = 0, m_ferr = 0, m_ovr = 0;
  logic [7:0] m_bits = 0, m_data = 0;

  always @(posedge clk) begin
    bit comp;
    comp = 0;
    if (!rst_n) begin
      m_tk = -1; m_len = 8; m_pe = 0; m_po = 0; m_prev = 1;
      m_av = 0; m_perr = 0; m_ferr = 0; m_ovr = 0; m_data = 0;
    end else begin
      if (tick) begin
        if (m_tk < 0) begin
          if (m_prev && !rxd) begin
            m_tk = 0; f_len = m_len; f_pe = m_pe; f_po = m_po; m_bits = 0;
          end
        end else begin
          m_tk++;
          if (m_tk == 8) begin
            if (rxd) m_tk = -1;
          end else if (m_tk > 8 && (m_tk - 8) % 16 == 0) begin
            int k;
            k = (m_tk - 8) / 16;
            if (k <= f_len) m_bits[k-1] = rxd;
            else if (f_pe && k == f_len + 1) m_pb = rxd;
            else begin
              comp = 1; m_tk = -1;
            end
          end
        end
        m_prev = rxd;
      end
      if (comp) begin
        m_ovr  = m_av && !clr_avail;
        m_av   = 1;
        m_data = m_bits;
        m_perr = f_pe && ((^m_bits ^ m_pb) != f_po);
        m_ferr = !rxd;
      end else if (clr_avail) m_av = 0;
      if (cfg_strobe) begin
        m_len = 5 + cfg_len; m_pe = cfg_par_en; m_po = cfg_par_odd;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk(rd_data == (data_oe ? m_data : 8'h00), "R3 rd_data", rd_data, data_oe ? m_data : 0);
      chk(data_avail == m_av, "R5 data_avail", data_avail, m_av);
      chk(par_err == (stat_oe & m_perr), "R6 par_err", par_err, stat_oe & m_perr);
      chk(frm_err == (stat_oe & m_ferr), "R7 frm_err", frm_err, stat_oe & m_ferr);
      chk(overrun == (stat_oe & m_ovr), "R8 overrun", overrun, stat_oe & m_ovr);
    end
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wt(input int n);
    repeat (n) begin
      do @(negedge clk); while (!tick);
    end
  endtask

  task automatic send(input logic [7:0] d, input int n, input bit pe, input bit po,
                      input bit flip_par, input bit stop_v);
    logic [7:0] m;
    m = d & ((8'h1 << n) - 1);
    rxd = 1'b0; wt(16);
    for (int i = 0; i < n; i++) begin rxd = m[i]; wt(16); end
    if (pe) begin rxd = (^m) ^ po ^ flip_par; wt(16); end
    rxd = stop_v; wt(16);
    rxd = 1'b1; wt(20);
  endtask

  task automatic setcfg(input logic [1:0] l, input bit pe, input bit po);
    @(negedge clk);
    cfg_len = l; cfg_par_en = pe; cfg_par_odd = po; cfg_strobe = 1'b1;
    @(negedge clk); cfg_strobe = 1'b0;
  endtask

  task automatic clear();
    @(negedge clk); clr_avail = 1'b1;
    @(negedge clk); clr_avail = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!data_avail && rd_data == 0 && !par_err && !frm_err && !overrun, "R5 reset", data_avail, 0);

    // R2 R3 R4: default 8 data bits, no parity
    send(8'hA5, 8, 0, 0, 0, 1);
    chk(rd_data == 8'hA5, "R2 8-bit byte", rd_data, 8'hA5);
    chk(data_avail, "R5 avail set", data_avail, 1);
    clear();
    chk(!data_avail, "R5 avail cleared", data_avail, 0);

    // R1: glitch shorter than half a bit
    rxd = 1'b0; wt(3); rxd = 1'b1; wt(40);
    chk(!data_avail && rd_data == 8'hA5, "R1 glitch ignored", rd_data, 8'hA5);

    // R4 R6: 5 bits, even parity
    setcfg(2'b00, 1, 0);
    send(8'h13, 5, 1, 0, 0, 1);
    chk(rd_data == 8'h13 && !par_err, "R6 even good", rd_data, 8'h13);
    clear();
    send(8'hFF, 5, 1, 0, 1, 1);
    chk(rd_data == 8'h1F && par_err, "R3 R6 even bad, upper zero", {par_err, rd_data}, 9'h11F);
    clear();

    // R6: 7 bits, odd parity
    setcfg(2'b10, 1, 1);
    send(8'h55, 7, 1, 1, 0, 1);
    chk(rd_data == 8'h55 && !par_err, "R6 odd good", rd_data, 8'h55);
    clear();
    send(8'h2A, 7, 1, 1, 1, 1);
    chk(par_err == 1, "R6 odd bad", par_err, 1);
    clear();

    // R7: stop bit 0, then a clean frame on 6 bits without parity
    setcfg(2'b01, 0, 0);
    send(8'h21, 6, 0, 0, 0, 0);
    chk(frm_err == 1 && rd_data == 8'h21, "R7 frame error", frm_err, 1);
    clear();
    send(8'h3C, 6, 0, 0, 0, 1);
    chk(frm_err == 0 && rd_data == 8'h3C, "R7 R9 flag rewritten", rd_data, 8'h3C);

    // R8: overrun, newer byte kept
    send(8'h0F, 6, 0, 0, 0, 1);
    chk(overrun == 1 && rd_data == 8'h0F, "R8 overrun", rd_data, 8'h0F);

    // R9 R3: output enables
    @(negedge clk); stat_oe = 1'b0; data_oe = 1'b0;
    @(negedge clk);
    chk(overrun == 0 && rd_data == 0, "R9 gated", overrun, 0);
    stat_oe = 1'b1; data_oe = 1'b1;
    @(negedge clk);
    chk(overrun == 1, "R9 flag held", overrun, 1);
    clear();

    // R10: no ticks, line activity ignored
    @(negedge clk); tick_en = 1'b0;
    repeat (8) @(negedge clk);
    rxd = 1'b0; repeat (300) @(negedge clk); rxd = 1'b1;
    repeat (8) @(negedge clk); tick_en = 1'b1;
    wt(200);
    chk(!data_avail && rd_data == 8'h0F, "R10 frozen without tick", data_avail, 0);

    // R4: back to 8 bits, config change after start edge does not affect frame
    setcfg(2'b11, 0, 0);
    fork
      send(8'hC3, 8, 0, 0, 0, 1);
      begin wt(4); setcfg(2'b00, 0, 0); end
    join
    chk(rd_data == 8'hC3, "R4 latched at start", rd_data, 8'hC3);

    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule